// File: doc/BRIEF.md
# Scoreboarded Warp Issue Scheduler

The scheduler sits between instruction fetch and the execution unit of a many-thread SIMD core. It keeps one instruction slot for each resident warp. Each cycle it can take one fetched instruction into the empty slot of the warp that fetched it. Each cycle it can also issue one buffered instruction to the execution unit. A per-warp register scoreboard decides which warps may issue: an instruction may go only when neither of its source registers and its destination register is still waiting for a result. The block is used to hide long-latency operations, because a stalled warp does not block the other warps behind it.

When more than one warp is eligible, the one whose instruction has waited longest wins. A tie goes to the first slot after the previous winner in circular order. One issued instruction holds the execution unit for a fixed number of cycles, so the next issue waits until the unit is free. Writeback events from the execution side clear pending registers. Fetch requests are produced per warp and are withdrawn while that warp's slot is occupied.

Top module: `wis_issue_sched`

## Requirements
- R1: After reset no instruction is issued, every warp's fetch request is high, and no register is pending.
- R2: A fill with `fill_valid` high stores the instruction (sources, destination, payload) in the slot of warp `fill_warp` when that slot is empty. At most one fill is accepted per cycle.
- R3: `fetch_req[w]` is low exactly while slot w holds an instruction. A fill aimed at an occupied slot is ignored, and the buffered instruction is issued later unchanged.
- R4: A buffered instruction is eligible only when none of its two source registers and its destination register is pending in its own warp's scoreboard. Scoreboards of different warps are independent.
- R5: Issuing an instruction marks its destination register pending for that warp. A writeback (`wb_valid`, `wb_warp`, `wb_reg`) clears that mark, and a waiting instruction can be selected at the first edge after the clearing edge.
- R6: When a writeback and an issue name the same warp and register at the same edge, the register stays pending.
- R7: After an issue, the next issue comes no earlier than OCC_CYCLES cycles later. With an eligible instruction waiting, it comes exactly OCC_CYCLES cycles later.
- R8: Each slot counts the cycles since it was filled, saturating at 2^AGE_W-1. Among eligible slots the one with the largest count is issued.
- R9: Among eligible slots with equal counts, the first slot in circular index order after the previous winner is issued. Before any issue the previous winner is taken as slot NUM_WARPS-1.
- R10: An issue is selected at a clock edge and appears on `issue_valid`, `issue_warp`, `issue_dst` and `issue_payload` for exactly one cycle after that edge, carrying the slot's stored fields. The slot is empty from that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_valid | input | 1 | Fetched instruction present |
| fill_warp | input | $clog2(NUM_WARPS) | Warp of the fetched instruction |
| fill_dst | input | $clog2(NUM_REGS) | Destination register |
| fill_src_a | input | $clog2(NUM_REGS) | First source register |
| fill_src_b | input | $clog2(NUM_REGS) | Second source register |
| fill_payload | input | PAY_W | Opaque instruction bits |
| fetch_req | output | NUM_WARPS | Per-warp request for a new instruction |
| wb_valid | input | 1 | Result written back |
| wb_warp | input | $clog2(NUM_WARPS) | Warp of the writeback |
| wb_reg | input | $clog2(NUM_REGS) | Register written back |
| issue_valid | output | 1 | Instruction issued this cycle |
| issue_warp | output | $clog2(NUM_WARPS) | Warp of the issued instruction |
| issue_dst | output | $clog2(NUM_REGS) | Destination of the issued instruction |
| issue_payload | output | PAY_W | Payload of the issued instruction |

## Verification
A four-warp, four-register configuration with a 2-bit age counter is driven by a cycle-level reference model for thousands of cycles, in phases that each tilt the traffic. Sparse fills with prompt writebacks separate plain fill and issue from the arbitration. Saturated fills into occupied slots expose any overwrite or any fetch request that is not withdrawn. Withheld writebacks against a small register set create dense hazards, and so test the source and destination checks per warp. A phase that returns a writeback to exactly the register being issued at that edge separates "set wins" from "clear wins". Because the age counter is short, ages saturate often, so round-robin tie breaking is exercised as often as oldest-first selection.

// File: rtl/wis_pkg.sv
package wis_pkg;

   // Slot index visited at step k of a circular scan that starts just after last.
   function automatic int ring_next(input int last, input int k, input int n);
      return (last + 1 + k) % n;
   endfunction

endpackage

// File: rtl/wis_slot.sv
module wis_slot #(
   parameter int REG_W = 6,
   parameter int PAY_W = 32,
   parameter int AGE_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fill_en,
   input  logic [REG_W-1:0] fill_dst,
   input  logic [REG_W-1:0] fill_src_a,
   input  logic [REG_W-1:0] fill_src_b,
   input  logic [PAY_W-1:0] fill_pay,
   input  logic             take,
   output logic             occ_q,
   output logic [REG_W-1:0] dst_q,
   output logic [REG_W-1:0] src_a_q,
   output logic [REG_W-1:0] src_b_q,
   output logic [PAY_W-1:0] pay_q,
   output logic [AGE_W-1:0] age_q
);
   localparam logic [AGE_W-1:0] AGE_MAX = '1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         occ_q   <= 1'b0;
         dst_q   <= '0;
         src_a_q <= '0;
         src_b_q <= '0;
         pay_q   <= '0;
         age_q   <= '0;
      end else if (take) begin
         occ_q <= 1'b0;
      end else if (fill_en && !occ_q) begin
         occ_q   <= 1'b1;
         dst_q   <= fill_dst;
         src_a_q <= fill_src_a;
         src_b_q <= fill_src_b;
         pay_q   <= fill_pay;
         age_q   <= '0;
      end else if (occ_q && age_q != AGE_MAX) begin
         age_q <= age_q + 1'b1;
      end
   end

   // R3
   fill_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && occ_q && !take) |=> (occ_q && $stable(pay_q) && $stable(dst_q)));

   // R8
   age_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && !occ_q) |=> (occ_q && age_q == '0));

endmodule

// File: rtl/wis_scoreboard.sv
module wis_scoreboard #(
   parameter int NUM_WARPS = 24,
   parameter int NUM_REGS  = 64,
   localparam int WID_W    = $clog2(NUM_WARPS),
   localparam int REG_W    = $clog2(NUM_REGS)
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 set_en,
   input  logic [WID_W-1:0]                     set_w,
   input  logic [REG_W-1:0]                     set_r,
   input  logic                                 clr_en,
   input  logic [WID_W-1:0]                     clr_w,
   input  logic [REG_W-1:0]                     clr_r,
   output logic [NUM_WARPS-1:0][NUM_REGS-1:0]   pend_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
      end else begin
         for (int w = 0; w < NUM_WARPS; w++) begin
            for (int r = 0; r < NUM_REGS; r++) begin
               if (set_en && set_w == WID_W'(w) && set_r == REG_W'(r))
                  pend_q[w][r] <= 1'b1;
               else if (clr_en && clr_w == WID_W'(w) && clr_r == REG_W'(r))
                  pend_q[w][r] <= 1'b0;
            end
         end
      end
   end

   // R6
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_en && clr_en && set_w == clr_w && set_r == clr_r)
      |=> pend_q[$past(set_w)][$past(set_r)]);

   // R5
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && !(set_en && set_w == clr_w && set_r == clr_r))
      |=> !pend_q[$past(clr_w)][$past(clr_r)]);

endmodule

// File: rtl/wis_arbiter.sv
module wis_arbiter #(
   parameter int N     = 24,
   parameter int AGE_W = 6,
   localparam int WID_W = $clog2(N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     req,
   input  logic [AGE_W-1:0] age [N],
   input  logic [WID_W-1:0] last,
   output logic             gnt_v,
   output logic [WID_W-1:0] gnt_idx
);
   logic [AGE_W-1:0] best_age;

   // Circular scan from the slot after the last winner; strict '>' keeps the
   // first slot in scan order on equal ages.
   always_comb begin
      gnt_v    = 1'b0;
      gnt_idx  = '0;
      best_age = '0;
      for (int k = 0; k < N; k++) begin
         int i;
         i = wis_pkg::ring_next(int'(last), k, N);
         if (req[i] && (!gnt_v || age[i] > best_age)) begin
            gnt_v    = 1'b1;
            gnt_idx  = WID_W'(i);
            best_age = age[i];
         end
      end
   end

   // R8
   any_req_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|req) |-> gnt_v);

   // R4
   grant_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_v |-> req[gnt_idx]);

endmodule

// File: rtl/wis_issue_sched.sv
module wis_issue_sched #(
   parameter int NUM_WARPS  = 24,
   parameter int NUM_REGS   = 64,
   parameter int PAY_W      = 32,
   parameter int AGE_W      = 6,
   parameter int OCC_CYCLES = 4,
   localparam int WID_W     = $clog2(NUM_WARPS),
   localparam int REG_W     = $clog2(NUM_REGS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 fill_valid,
   input  logic [WID_W-1:0]     fill_warp,
   input  logic [REG_W-1:0]     fill_dst,
   input  logic [REG_W-1:0]     fill_src_a,
   input  logic [REG_W-1:0]     fill_src_b,
   input  logic [PAY_W-1:0]     fill_payload,
   output logic [NUM_WARPS-1:0] fetch_req,
   input  logic                 wb_valid,
   input  logic [WID_W-1:0]     wb_warp,
   input  logic [REG_W-1:0]     wb_reg,
   output logic                 issue_valid,
   output logic [WID_W-1:0]     issue_warp,
   output logic [REG_W-1:0]     issue_dst,
   output logic [PAY_W-1:0]     issue_payload
);
   localparam logic [WID_W-1:0] LAST_INIT = WID_W'(NUM_WARPS - 1);

   if (NUM_WARPS < 2 || NUM_REGS < 2 || AGE_W < 1 || PAY_W < 1 || OCC_CYCLES < 1) begin : g_bad_cfg
      $error("wis_issue_sched: illegal parameter set");
   end

   logic                 occ   [NUM_WARPS];
   logic [REG_W-1:0]     s_dst [NUM_WARPS];
   logic [REG_W-1:0]     s_sa  [NUM_WARPS];
   logic [REG_W-1:0]     s_sb  [NUM_WARPS];
   logic [PAY_W-1:0]     s_pay [NUM_WARPS];
   logic [AGE_W-1:0]     s_age [NUM_WARPS];
   logic [NUM_WARPS-1:0] elig;
   logic [NUM_WARPS-1:0] req;
   logic [NUM_WARPS-1:0][NUM_REGS-1:0] sb_pend;
   logic                 gnt_v;
   logic [WID_W-1:0]     gnt_idx;
   logic [WID_W-1:0]     last_q;
   logic                 unit_free;

   for (genvar w = 0; w < NUM_WARPS; w++) begin : g_slot
      wis_slot #(.REG_W(REG_W), .PAY_W(PAY_W), .AGE_W(AGE_W)) u_slot (
         .clk        (clk),
         .rst_n      (rst_n),
         .fill_en    (fill_valid && fill_warp == WID_W'(w)),
         .fill_dst   (fill_dst),
         .fill_src_a (fill_src_a),
         .fill_src_b (fill_src_b),
         .fill_pay   (fill_payload),
         .take       (gnt_v && gnt_idx == WID_W'(w)),
         .occ_q      (occ[w]),
         .dst_q      (s_dst[w]),
         .src_a_q    (s_sa[w]),
         .src_b_q    (s_sb[w]),
         .pay_q      (s_pay[w]),
         .age_q      (s_age[w])
      );
      assign fetch_req[w] = ~occ[w];
      assign elig[w] = occ[w] && !sb_pend[w][s_sa[w]] && !sb_pend[w][s_sb[w]]
                       && !sb_pend[w][s_dst[w]];
   end

   if (OCC_CYCLES > 1) begin : g_occ
      localparam int BUSY_W = $clog2(OCC_CYCLES);
      logic [BUSY_W-1:0] busy_q;
      always_ff @(posedge clk) begin
         if (!rst_n)             busy_q <= '0;
         else if (gnt_v)         busy_q <= BUSY_W'(OCC_CYCLES - 1);
         else if (busy_q != '0)  busy_q <= busy_q - 1'b1;
      end
      assign unit_free = (busy_q == '0);

      // R7
      unit_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
         issue_valid |=> !issue_valid);
   end else begin : g_no_occ
      assign unit_free = 1'b1;
   end

   assign req = unit_free ? elig : '0;

   wis_arbiter #(.N(NUM_WARPS), .AGE_W(AGE_W)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req),
      .age     (s_age),
      .last    (last_q),
      .gnt_v   (gnt_v),
      .gnt_idx (gnt_idx)
   );

   wis_scoreboard #(.NUM_WARPS(NUM_WARPS), .NUM_REGS(NUM_REGS)) u_sb (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (gnt_v),
      .set_w  (gnt_idx),
      .set_r  (s_dst[gnt_idx]),
      .clr_en (wb_valid),
      .clr_w  (wb_warp),
      .clr_r  (wb_reg),
      .pend_q (sb_pend)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         issue_valid   <= 1'b0;
         issue_warp    <= '0;
         issue_dst     <= '0;
         issue_payload <= '0;
         last_q        <= LAST_INIT;
      end else begin
         issue_valid <= gnt_v;
         if (gnt_v) begin
            issue_warp    <= gnt_idx;
            issue_dst     <= s_dst[gnt_idx];
            issue_payload <= s_pay[gnt_idx];
            last_q        <= gnt_idx;
         end
      end
   end

   // R10
   issued_slot_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> fetch_req[issue_warp]);

   // R5
   dst_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> sb_pend[issue_warp][issue_dst]);

endmodule

// File: tb/test_wis_issue_sched.sv
`timescale 1ns/1ps
module test_wis_issue_sched;
   localparam int NW = 4, NR = 4, PW = 8, AW = 2, OCC = 4;
   localparam int AMAX = (1 << AW) - 1;
   localparam int NPH = 9;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic          fill_valid = 0;
   logic [1:0]    fill_warp = 0, fill_dst = 0, fill_src_a = 0, fill_src_b = 0;
   logic [PW-1:0] fill_payload = 0;
   logic [NW-1:0] fetch_req;
   logic          wb_valid = 0;
   logic [1:0]    wb_warp = 0, wb_reg = 0;
   logic          issue_valid;
   logic [1:0]    issue_warp, issue_dst;
   logic [PW-1:0] issue_payload;

   wis_issue_sched #(.NUM_WARPS(NW), .NUM_REGS(NR), .PAY_W(PW), .AGE_W(AW),
                     .OCC_CYCLES(OCC)) i_wis_issue_sched (
      .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .fill_warp(fill_warp),
      .fill_dst(fill_dst), .fill_src_a(fill_src_a), .fill_src_b(fill_src_b),
      .fill_payload(fill_payload), .fetch_req(fetch_req), .wb_valid(wb_valid),
      .wb_warp(wb_warp), .wb_reg(wb_reg), .issue_valid(issue_valid),
      .issue_warp(issue_warp), .issue_dst(issue_dst), .issue_payload(issue_payload));

   int checks = 0, fails = 0;
   bit done = 0;
   string cur_req = "R1";

   // Reference model state, built from the requirements.
   int m_occ[NW], m_dst[NW], m_sa[NW], m_sb[NW], m_pay[NW], m_age[NW];
   bit m_pend[NW][NR];
   int m_busy, m_last, m_iv, m_iw, m_idst, m_ipay;
   logic [31:0] rng = 32'h1357_9bdf;

   function automatic int roll(input int m);
      rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
      return int'(rng[23:8]) % m;
   endfunction

   task automatic m_reset();
      for (int w = 0; w < NW; w++) begin
         m_occ[w] = 0; m_dst[w] = 0; m_sa[w] = 0; m_sb[w] = 0; m_pay[w] = 0; m_age[w] = 0;
         for (int r = 0; r < NR; r++) m_pend[w][r] = 0;
      end
      m_busy = 0; m_last = NW - 1; m_iv = 0; m_iw = 0; m_idst = 0; m_ipay = 0;
   endtask

   function automatic int m_pick();
      int best = -1;
      if (m_busy != 0) return -1;
      for (int k = 0; k < NW; k++) begin
         int i = (m_last + 1 + k) % NW;
         if (m_occ[i] != 0 && !m_pend[i][m_sa[i]] && !m_pend[i][m_sb[i]] && !m_pend[i][m_dst[i]])
            if (best < 0 || m_age[i] > m_age[best]) best = i;
      end
      return best;
   endfunction

   task automatic m_step();
      int p = m_pick();
      int fw = int'(fill_warp);
      for (int w = 0; w < NW; w++) begin
         if (w == p) m_occ[w] = 0;
         else if (fill_valid && w == fw && m_occ[w] == 0) begin
            m_occ[w] = 1; m_dst[w] = int'(fill_dst); m_sa[w] = int'(fill_src_a);
            m_sb[w] = int'(fill_src_b); m_pay[w] = int'(fill_payload); m_age[w] = 0;
         end else if (m_occ[w] != 0 && m_age[w] < AMAX) m_age[w]++;
      end
      if (wb_valid) m_pend[wb_warp][wb_reg] = 0;
      if (p >= 0) begin
         m_pend[p][m_dst[p]] = 1;
         m_iv = 1; m_iw = p; m_idst = m_dst[p]; m_ipay = m_pay[p];
         m_busy = OCC - 1; m_last = p;
      end else begin
         m_iv = 0;
         if (m_busy > 0) m_busy--;
      end
   endtask

   task automatic check_outputs();
      logic [NW-1:0] exp_fr;
      bit bad;
      for (int w = 0; w < NW; w++) exp_fr[w] = (m_occ[w] == 0);
      bad = (int'(issue_valid) != m_iv) || (fetch_req !== exp_fr);
      if (m_iv != 0)
         bad = bad || int'(issue_warp) != m_iw || int'(issue_dst) != m_idst
               || int'(issue_payload) != m_ipay;
      checks++;
      if (bad) begin
         fails++;
         $display("FAIL %s: got v=%0d w=%0d d=%0d p=%0h fr=%b, expected v=%0d w=%0d d=%0d p=%0h fr=%b",
                  cur_req, issue_valid, issue_warp, issue_dst, issue_payload, fetch_req,
                  m_iv, m_iw, m_idst, m_ipay, exp_fr);
      end
   endtask

   // Per phase: requirement tag, fill percentage, writeback percentage,
   // writeback mode (0 random, 1 pending register, 2 same register as the issue).
   string ph_tag [NPH] = '{"R2", "R3", "R4", "R5", "R6", "R7", "R8", "R9", "R10"};
   int    ph_fill[NPH] = '{20, 100, 70, 50, 80, 90, 60, 100, 40};
   int    ph_wb  [NPH] = '{90, 50, 20, 60, 100, 90, 30, 70, 60};
   int    ph_mode[NPH] = '{1, 1, 0, 1, 2, 1, 0, 1, 1};

   initial begin
      m_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state visible on the ports
      cur_req = "R1";
      check_outputs();
      for (int ph = 0; ph < NPH; ph++) begin
         cur_req = ph_tag[ph];
         for (int c = 0; c < 400; c++) begin
            fill_valid   = roll(100) < ph_fill[ph];
            fill_warp    = 2'(roll(NW));
            fill_dst     = 2'(roll(NR));
            fill_src_a   = 2'(roll(NR));
            fill_src_b   = 2'(roll(NR));
            fill_payload = PW'(roll(256));
            wb_valid     = roll(100) < ph_wb[ph];
            wb_warp      = 2'(roll(NW));
            wb_reg       = 2'(roll(NR));
            if (ph_mode[ph] == 2) begin
               int p = m_pick();
               // R6: writeback lands on the register being issued at this edge
               if (p >= 0) begin
                  wb_valid = 1'b1; wb_warp = 2'(p); wb_reg = 2'(m_dst[p]);
               end
            end else if (ph_mode[ph] == 1 && wb_valid) begin
               int s = roll(NW * NR);
               for (int k = 0; k < NW * NR; k++) begin
                  int e = (s + k) % (NW * NR);
                  if (m_pend[e / NR][e % NR]) begin
                     wb_warp = 2'(e / NR); wb_reg = 2'(e % NR); break;
                  end
               end
            end
            m_step();
            @(negedge clk);
            check_outputs();
         end
      end
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: got no completion, expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule